// File: doc/BRIEF.md
# Register Rename Status Table

This block is an architectural register file in which every register also holds a producer tag. The tag names the reservation station or load buffer entry that will write the register next. A tag of zero means the stored value is current. Two combinational read ports serve the source operands of an instruction at issue. Each port returns the register value when the tag is zero. When the tag is nonzero it returns the tag and a zero value, so the consumer waits for that producer instead.

An issue port retags the destination register with the identifier of its new producer, so only the most recent writer owns the register. A result broadcast bus carries a producer tag and its data. A register takes the data, and its tag returns to zero, only when its current tag equals the broadcast tag. A result from a producer that has since been superseded therefore never reaches the register, even if it completes last. This removes write-after-read and write-after-write hazards without stalling.

Top module: `rename_status_table`

## Requirements
- R1: The asynchronous active-low reset sets every register's tag and value to zero, and reads then return tag 0 and value 0.
- R2: Each of the two read ports returns the addressed register independently. A nonzero tag is returned with value 0, and tag 0 is returned with the stored value.
- R3: When `iss_valid` is high, the register `iss_dst` holds tag `iss_tag` from the next cycle on. `iss_tag` must be nonzero.
- R4: A broadcast (`bc_valid`, nonzero `bc_tag`) whose tag equals a register's tag makes that register hold `bc_data` with tag 0 from the next cycle on.
- R5: A broadcast whose tag differs from a register's tag leaves that register's tag and value unchanged, including a late result from a superseded producer.
- R6: If a register is retagged and a broadcast matching its old tag arrive in the same cycle, the retag wins and the register holds the new tag afterwards.
- R7: A read in the same cycle as a broadcast matching the read register's tag returns tag 0 and `bc_data`.
- R8: A read in the same cycle as a retag of the same register returns the state from before the retag.
- R9: A broadcast with tag 0 has no effect on any register and is not bypassed to a read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | IDX_W | Read port A register index |
| rd_a_val | output | DATA_W | Read port A value (0 while a producer is pending) |
| rd_a_tag | output | TAG_W | Read port A producer tag (0 = value current) |
| rd_b_idx | input | IDX_W | Read port B register index |
| rd_b_val | output | DATA_W | Read port B value (0 while a producer is pending) |
| rd_b_tag | output | TAG_W | Read port B producer tag (0 = value current) |
| iss_valid | input | 1 | Retag the destination register this cycle |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | New producer identifier, nonzero |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Producer tag of the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |

## Verification
The bench builds the block with 8 registers, 16-bit data and 4-bit tags. Fifteen distinct producer identifiers keep a superseded tag, its replacement and an unrelated pending tag apart. Three-bit indices let both read ports look at the renamed register and a bystander in the same cycle. The sequences it can reach include a double rename followed by the stale result, a retag colliding with a matching broadcast, a broadcast carrying tag 0 while a ready register is read, and an asynchronous reset taken while a tag is pending.

// File: rtl/rstat_pkg.sv
package rstat_pkg;

  // Update applied to one register entry in a cycle; retag has priority.
  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_RETAG   = 2'd1,
    UPD_CAPTURE = 2'd2
  } upd_e;

  localparam int unsigned NUM_RD_PORTS = 2;

endpackage

// File: rtl/rstat_entry.sv
module rstat_entry
  import rstat_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned INDEX  = 0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [DATA_W-1:0] ent_val,
  output logic [TAG_W-1:0]  ent_tag
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(INDEX);

  logic [DATA_W-1:0] val_q, val_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              upd_en;
  upd_e              upd;

  // Next-state: retag of this entry beats a matching broadcast.
  always_comb begin
    upd = UPD_HOLD;
    if (iss_valid && (iss_dst == MY_IDX)) begin
      upd = UPD_RETAG;
    end else if (bc_valid && (tag_q != '0) && (bc_tag == tag_q)) begin
      upd = UPD_CAPTURE;
    end
  end

  always_comb begin
    val_d = val_q;
    tag_d = tag_q;
    case (upd)
      UPD_RETAG:   tag_d = iss_tag;
      UPD_CAPTURE: begin
        val_d = bc_data;
        tag_d = '0;
      end
      default: ;
    endcase
  end

  assign upd_en = (upd != UPD_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      tag_q <= '0;
    end else if (upd_en) begin
      val_q <= val_d;
      tag_q <= tag_d;
    end
  end

  assign ent_val = val_q;
  assign ent_tag = tag_q;

endmodule

// File: rtl/rstat_rdport.sv
module rstat_rdport #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned IDX_W    = 3
)(
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] ent_val,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag,
  input  logic                            bc_valid,
  input  logic [TAG_W-1:0]                bc_tag,
  input  logic [DATA_W-1:0]               bc_data,
  output logic [DATA_W-1:0]               rd_val,
  output logic [TAG_W-1:0]                rd_tag
);

  logic [DATA_W-1:0] sel_val;
  logic [TAG_W-1:0]  sel_tag;
  logic              bc_hit;

  always_comb begin
    sel_val = '0;
    sel_tag = '0;
    if (32'(rd_idx) < NUM_REGS) begin
      sel_val = ent_val[rd_idx];
      sel_tag = ent_tag[rd_idx];
    end
  end

  // Same-cycle forwarding of a result the register is waiting for.
  assign bc_hit = bc_valid && (sel_tag != '0) && (bc_tag == sel_tag);

  always_comb begin
    if (bc_hit) begin
      rd_val = bc_data;
      rd_tag = '0;
    end else if (sel_tag != '0) begin
      rd_val = '0;
      rd_tag = sel_tag;
    end else begin
      rd_val = sel_val;
      rd_tag = '0;
    end
  end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rstat_pkg::*;
#(
  parameter  int unsigned NUM_REGS = 8,
  parameter  int unsigned DATA_W   = 16,
  parameter  int unsigned TAG_W    = 4,
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_val,
  output logic [TAG_W-1:0]  rd_a_tag,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_val,
  output logic [TAG_W-1:0]  rd_b_tag,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data
);

  logic [NUM_REGS-1:0][DATA_W-1:0]     ent_val;
  logic [NUM_REGS-1:0][TAG_W-1:0]      ent_tag;
  logic [NUM_RD_PORTS-1:0][IDX_W-1:0]  rp_idx;
  logic [NUM_RD_PORTS-1:0][DATA_W-1:0] rp_val;
  logic [NUM_RD_PORTS-1:0][TAG_W-1:0]  rp_tag;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    rstat_entry #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .IDX_W  (IDX_W),
      .INDEX  (r)
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .iss_dst   (iss_dst),
      .iss_tag   (iss_tag),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .ent_val   (ent_val[r]),
      .ent_tag   (ent_tag[r])
    );
  end

  assign rp_idx = {rd_b_idx, rd_a_idx};

  for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_rd
    rstat_rdport #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .TAG_W    (TAG_W),
      .IDX_W    (IDX_W)
    ) u_rd (
      .rd_idx   (rp_idx[p]),
      .ent_val  (ent_val),
      .ent_tag  (ent_tag),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .rd_val   (rp_val[p]),
      .rd_tag   (rp_tag[p])
    );
  end

  assign rd_a_val = rp_val[0];
  assign rd_a_tag = rp_tag[0];
  assign rd_b_val = rp_val[1];
  assign rd_b_tag = rp_tag[1];

endmodule

// File: rtl/rstat_chk.sv
module rstat_chk #(
  parameter  int unsigned NUM_REGS = 8,
  parameter  int unsigned DATA_W   = 16,
  parameter  int unsigned TAG_W    = 4,
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
)(
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_val,
  input logic [TAG_W-1:0]  rd_a_tag,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_val,
  input logic [TAG_W-1:0]  rd_b_tag,
  input logic              iss_valid,
  input logic [IDX_W-1:0]  iss_dst,
  input logic [TAG_W-1:0]  iss_tag,
  input logic              bc_valid,
  input logic [TAG_W-1:0]  bc_tag,
  input logic [DATA_W-1:0] bc_data
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (rd_a_tag == '0 && rd_a_val == '0 &&
                               rd_b_tag == '0 && rd_b_val == '0);
    end
  end

  // R3
  issue_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_tag != '0));

  // R3
  retag_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> ((rd_a_idx != $past(iss_dst)) ||
                   (bc_valid && (bc_tag == $past(iss_tag))) ||
                   (rd_a_tag == $past(iss_tag))));

  // R7
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && (bc_tag != '0)) |-> (rd_a_tag != bc_tag));

  // R7
  bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && (bc_tag != '0)) |-> (rd_b_tag != bc_tag));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_a_tag == '0) && !(iss_valid && (iss_dst == rd_a_idx))) |=>
      ((rd_a_idx != $past(rd_a_idx)) ||
       ((rd_a_tag == '0) && (rd_a_val == $past(rd_a_val)))));

endmodule

bind rename_status_table rstat_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .TAG_W    (TAG_W)
) u_rstat_chk (.*);

// File: tb/test_rename_status_table.sv
`timescale 1ns/1ps
module test_rename_status_table;

  localparam int unsigned NR = 8;
  localparam int unsigned DW = 16;
  localparam int unsigned TW = 4;
  localparam int unsigned IW = 3;

  logic          clk;
  logic          rst_n;
  logic [IW-1:0] rd_a_idx, rd_b_idx, iss_dst;
  logic [DW-1:0] rd_a_val, rd_b_val, bc_data;
  logic [TW-1:0] rd_a_tag, rd_b_tag, iss_tag, bc_tag;
  logic          iss_valid, bc_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  rename_status_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) i_rename_status_table (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_val(rd_a_val), .rd_a_tag(rd_a_tag),
    .rd_b_idx(rd_b_idx), .rd_b_val(rd_b_val), .rd_b_tag(rd_b_tag),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic          iv;
    logic [IW-1:0] idst;
    logic [TW-1:0] itag;
    logic          bv;
    logic [TW-1:0] btag;
    logic [DW-1:0] bdata;
    logic [IW-1:0] ra;
    logic [TW-1:0] eat;
    logic [DW-1:0] eav;
    logic [IW-1:0] rb;
    logic [TW-1:0] ebt;
    logic [DW-1:0] ebv;
    logic [3:0]    qa;   // requirement number checked on port A
    logic [3:0]    qb;   // requirement number checked on port B
  } vec_t;

  localparam int NV = 15;
  // Outputs are those seen during the row's cycle, before its clock edge.
  localparam vec_t VEC [NV] = '{
    // R8: retag r3 to 5, same-cycle read shows old state
    '{1'b1, 3'd3, 4'd5, 1'b0, 4'd0, 16'h0000, 3'd3, 4'd0, 16'h0000, 3'd0, 4'd0, 16'h0000, 4'd8, 4'd2},
    // R3: r3 now tag 5; r4 retag to 6, read of r4 pre-retag
    '{1'b1, 3'd4, 4'd6, 1'b0, 4'd0, 16'h0000, 3'd3, 4'd5, 16'h0000, 3'd4, 4'd0, 16'h0000, 4'd3, 4'd8},
    // R7: broadcast tag 5 bypassed on A; R2: B pending gives value 0
    '{1'b0, 3'd0, 4'd0, 1'b1, 4'd5, 16'h1111, 3'd3, 4'd0, 16'h1111, 3'd4, 4'd6, 16'h0000, 4'd7, 4'd2},
    // R4: r3 captured
    '{1'b0, 3'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 3'd3, 4'd0, 16'h1111, 3'd4, 4'd6, 16'h0000, 4'd4, 4'd5},
    // rename r3 to 7
    '{1'b1, 3'd3, 4'd7, 1'b0, 4'd0, 16'h0000, 3'd3, 4'd0, 16'h1111, 3'd2, 4'd0, 16'h0000, 4'd8, 4'd2},
    // rename r3 again to 8, tag 7 superseded
    '{1'b1, 3'd3, 4'd8, 1'b0, 4'd0, 16'h0000, 3'd3, 4'd7, 16'h0000, 3'd2, 4'd0, 16'h0000, 4'd3, 4'd2},
    // R5: stale result tag 7 arrives, not bypassed
    '{1'b0, 3'd0, 4'd0, 1'b1, 4'd7, 16'h2222, 3'd3, 4'd8, 16'h0000, 3'd3, 4'd8, 16'h0000, 4'd5, 4'd5},
    // R5: r3 untouched by stale result
    '{1'b0, 3'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 3'd3, 4'd8, 16'h0000, 3'd4, 4'd6, 16'h0000, 4'd5, 4'd5},
    // R6: retag r3 to 9 while tag 8 broadcasts; read bypasses (R7)
    '{1'b1, 3'd3, 4'd9, 1'b1, 4'd8, 16'h3333, 3'd3, 4'd0, 16'h3333, 3'd4, 4'd6, 16'h0000, 4'd7, 4'd5},
    // R6: retag won
    '{1'b0, 3'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 3'd3, 4'd9, 16'h0000, 3'd4, 4'd6, 16'h0000, 4'd6, 4'd5},
    // R7: tag 9 broadcast bypassed on both ports
    '{1'b0, 3'd0, 4'd0, 1'b1, 4'd9, 16'h4444, 3'd3, 4'd0, 16'h4444, 3'd3, 4'd0, 16'h4444, 4'd7, 4'd7},
    // R9: tag-0 broadcast not bypassed to ready registers
    '{1'b0, 3'd0, 4'd0, 1'b1, 4'd0, 16'h5555, 3'd3, 4'd0, 16'h4444, 3'd0, 4'd0, 16'h0000, 4'd9, 4'd9},
    // R9: tag-0 broadcast left registers unchanged
    '{1'b0, 3'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 3'd0, 4'd0, 16'h0000, 3'd3, 4'd0, 16'h4444, 4'd9, 4'd9},
    // R7: tag 6 broadcast for r4 seen on both ports
    '{1'b0, 3'd0, 4'd0, 1'b1, 4'd6, 16'h6666, 3'd4, 4'd0, 16'h6666, 3'd4, 4'd0, 16'h6666, 4'd7, 4'd7},
    // R4: r4 captured, r3 still holds its value
    '{1'b0, 3'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 3'd4, 4'd0, 16'h6666, 3'd3, 4'd0, 16'h4444, 4'd4, 4'd4}
  };

  task automatic chk(input int req, input string what,
                     input logic [TW-1:0] at, input logic [TW-1:0] et,
                     input logic [DW-1:0] av, input logic [DW-1:0] ev);
    n_chk++;
    if (at !== et || av !== ev) begin
      n_bad++;
      $display("FAIL R%0d %s: tag %0h expected %0h, value %0h expected %0h",
               req, what, at, et, av, ev);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 1'b0; iss_dst = '0; iss_tag = '0;
    bc_valid  = 1'b0; bc_tag  = '0; bc_data = '0;
    rd_a_idx  = '0;   rd_b_idx = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads tag 0, value 0 after reset
    for (int r = 0; r < int'(NR); r += 2) begin
      @(negedge clk);
      rd_a_idx = IW'(r);
      rd_b_idx = IW'(r + 1);
      #2;
      chk(1, "reset A", rd_a_tag, '0, rd_a_val, '0);
      chk(1, "reset B", rd_b_tag, '0, rd_b_val, '0);
    end

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      iss_valid = VEC[i].iv;  iss_dst = VEC[i].idst; iss_tag = VEC[i].itag;
      bc_valid  = VEC[i].bv;  bc_tag  = VEC[i].btag; bc_data = VEC[i].bdata;
      rd_a_idx  = VEC[i].ra;  rd_b_idx = VEC[i].rb;
      #2;
      chk(int'(VEC[i].qa), $sformatf("row %0d A", i), rd_a_tag, VEC[i].eat, rd_a_val, VEC[i].eav);
      chk(int'(VEC[i].qb), $sformatf("row %0d B", i), rd_b_tag, VEC[i].ebt, rd_b_val, VEC[i].ebv);
    end

    // R3 then R1: pending tag cleared by an asynchronous reset mid-cycle
    @(negedge clk);
    idle_inputs();
    iss_valid = 1'b1; iss_dst = 3'd5; iss_tag = 4'd3;
    @(negedge clk);
    idle_inputs();
    rd_a_idx = 3'd5;
    rd_b_idx = 3'd3;
    #2;
    chk(3, "retag r5", rd_a_tag, 4'd3, rd_a_val, '0);
    chk(2, "ready r3", rd_b_tag, '0, rd_b_val, 16'h4444);
    #1;
    rst_n = 1'b0;
    #1;
    chk(1, "async reset r5", rd_a_tag, '0, rd_a_val, '0);
    chk(1, "async reset r3", rd_b_tag, '0, rd_b_val, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule